// File: doc/BRIEF.md
# Selectable Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for two N-bit operands, with N set to 4 by default. A 4-bit function select picks one of sixteen operations. Bit 3 of the select chooses which result reaches the output: the arithmetic path or the bitwise path. Both paths are evaluated in parallel on every change of the inputs. A final multiplexer chooses one of the two results.

The arithmetic path uses a single ripple-carry adder. The adder's second operand is always X, and its carry-in is select bit 0. An operand-conditioning stage builds the adder's first operand from Y, using select bits 2 and 1. This one adder gives transfer, increment, add, add-plus-one, ones'- and two's-complement subtraction, and decrement. The logic path gives AND, OR, XOR and NOT of X. Besides the result, the block reports the adder's carry out of the top bit and a signed-overflow flag. It reports no other status.

Top module: `sel_alu`

## Requirements
- R1: When func_sel[3]=0, result carries the arithmetic result. When func_sel[3]=1, it carries the logic result, and func_sel[2] has no effect on any output.
- R2: With func_sel[3]=0 the codes func_sel[2:0] give: 000 X, 001 X+1, 010 X+Y, 011 X+Y+1, 100 X+~Y, 101 X+~Y+1 (X-Y), 110 X-1, 111 X. All sums wrap modulo 2^N.
- R3: The adder computes P+X+func_sel[0], where P is taken from func_sel[2:1]: 00 all-zeros, 01 Y, 10 ~Y, 11 all-ones. For codes 00 and 11, Y has no effect on any output.
- R4: With func_sel[3]=1 the codes func_sel[1:0] give: 00 X AND Y, 01 X OR Y, 10 X XOR Y, 11 NOT X (Y has no effect).
- R5: For arithmetic codes, carry_out is bit N of the (N+1)-bit sum P+X+func_sel[0].
- R6: For logic codes, carry_out is 0.
- R7: For arithmetic codes, overflow is 1 exactly when P and X have the same top bit and result's top bit differs from it. This equals the case where the signed sum P+X+func_sel[0] lies outside [-2^(N-1), 2^(N-1)-1]. The carry out alone is not the flag.
- R8: For logic codes, overflow is 0.
- R9: Decrementing the most negative value (X=1000 at N=4, code 0110) gives 0111 with carry_out=1 and overflow=1. Incrementing 0111 (code 0001) gives 1000 with carry_out=0 and overflow=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | WIDTH | Operand X, fed unchanged to the adder and to the logic unit |
| y_in | input | WIDTH | Operand Y, conditioned for the adder and fed to the logic unit |
| func_sel | input | 4 | Function select: bit 3 chooses the path, bits 2..0 the operation |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Adder carry out of the top bit, 0 for logic codes |
| overflow | output | 1 | Signed overflow of the adder, 0 for logic codes |

## Verification
The in-line assertions guard some properties whenever the inputs settle. Carry and overflow stay at zero on the logic path. A flagged overflow always shows a result sign that differs from X's sign. Transfer code 0000 passes X through cleanly. Two's-complement subtraction of equal operands gives zero with a carry. NOT ignores Y. The full arithmetic and logic tables, and the fact that Y and func_sel[2] have no effect where the requirements say so, can only be shown by the bench. It sweeps every select code over every operand pair against its own model, and adds directed cases at the -8 boundary.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;

    // Decoded view of the 4-bit function select; field order follows select bits 3..0.
    typedef struct packed {
        logic use_logic;   // bit 3: 1 = bitwise path, 0 = adder path
        logic p_inv;       // bit 2: contributes ~Y (adder path only)
        logic p_pass;      // bit 1: contributes  Y; also logic op high bit
        logic c_in;        // bit 0: adder carry-in; also logic op low bit
    } alu_sel_t;

    // Bitwise operation codes on select bits 1..0.
    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOT = 2'b11
    } logic_op_e;

endpackage

// File: rtl/sel_alu_operand_cond.sv
module sel_alu_operand_cond #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] y_val,
    input  logic             p_inv,
    input  logic             p_pass,
    output logic [WIDTH-1:0] p_val
);

    // Per bit: 00 -> 0, 01 -> Y, 10 -> ~Y, 11 -> 1.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign p_val[i] = (p_inv & ~y_val[i]) | (p_pass & y_val[i]);
    end

endmodule

// File: rtl/sel_alu_ripple_add.sv
module sel_alu_ripple_add #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] b_val,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum,
    output logic             c_out
);

    logic [WIDTH:0] chain;

    assign chain[0] = c_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        logic half;
        assign half         = a_val[i] ^ b_val[i];
        assign sum[i]       = half ^ chain[i];
        assign chain[i+1]   = (a_val[i] & b_val[i]) | (half & chain[i]);
    end

    assign c_out = chain[WIDTH];

endmodule

// File: rtl/sel_alu_logic_unit.sv
module sel_alu_logic_unit
    import sel_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_val,
    input  logic [WIDTH-1:0] y_val,
    input  logic [1:0]       op,
    output logic [WIDTH-1:0] out_val
);

    logic_op_e op_e;
    assign op_e = logic_op_e'(op);

    always_comb begin
        unique case (op_e)
            LOP_AND: out_val = x_val & y_val;
            LOP_OR:  out_val = x_val | y_val;
            LOP_XOR: out_val = x_val ^ y_val;
            LOP_NOT: out_val = ~x_val;
            default: out_val = '0;
        endcase
    end

    // R4: NOT depends on X alone
    always_comb begin
        if (op_e == LOP_NOT) begin
            a_r4_not_ignores_y: assert ((out_val ^ x_val) == {WIDTH{1'b1}})
                else $error("R4 NOT result is not the complement of X");
        end
    end

endmodule

// File: rtl/sel_alu.sv
module sel_alu
    import sel_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic [3:0]       func_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] value;
        logic             carry;
        logic             ovf;
    } alu_out_t;

    alu_sel_t         sel;
    logic [WIDTH-1:0] p_operand;
    logic [WIDTH-1:0] arith_sum;
    logic             arith_carry;
    logic [WIDTH-1:0] logic_val;
    alu_out_t         out_d;

    assign sel = alu_sel_t'(func_sel);

    sel_alu_operand_cond #(.WIDTH(WIDTH)) cond_i (
        .y_val  (y_in),
        .p_inv  (sel.p_inv),
        .p_pass (sel.p_pass),
        .p_val  (p_operand)
    );

    sel_alu_ripple_add #(.WIDTH(WIDTH)) add_i (
        .a_val (p_operand),
        .b_val (x_in),
        .c_in  (sel.c_in),
        .sum   (arith_sum),
        .c_out (arith_carry)
    );

    sel_alu_logic_unit #(.WIDTH(WIDTH)) lu_i (
        .x_val   (x_in),
        .y_val   (y_in),
        .op      ({sel.p_pass, sel.c_in}),
        .out_val (logic_val)
    );

    // Output selection; both paths run, only one is reported.
    always_comb begin
        out_d = '0;
        if (sel.use_logic) begin
            out_d.value = logic_val;
            out_d.carry = 1'b0;
            out_d.ovf   = 1'b0;
        end else begin
            out_d.value = arith_sum;
            out_d.carry = arith_carry;
            out_d.ovf   = (p_operand[MSB] == x_in[MSB]) &&
                          (arith_sum[MSB] != x_in[MSB]);
        end
    end

    assign result    = out_d.value;
    assign carry_out = out_d.carry;
    assign overflow  = out_d.ovf;

    always_comb begin
        if (func_sel[3]) begin
            a_r6_no_carry_logic: assert (!carry_out)
                else $error("R6 carry_out set on logic code");
            a_r8_no_overflow_logic: assert (!overflow)
                else $error("R8 overflow set on logic code");
        end
        if (!func_sel[3] && overflow) begin
            a_r7_ovf_flips_sign: assert (result[MSB] != x_in[MSB])
                else $error("R7 overflow without sign change");
        end
        if (func_sel == 4'b0000) begin
            a_r2_transfer_clean: assert (result == x_in && !carry_out && !overflow)
                else $error("R2 transfer code altered X");
        end
        if (func_sel == 4'b0101 && x_in == y_in) begin
            a_r5_self_sub_zero: assert (result == '0 && carry_out)
                else $error("R5 X-X did not give zero with carry");
        end
    end

endmodule

// File: tb/sel_alu_tb_top.sv
module sel_alu_tb_top;

    localparam int W    = 4;
    localparam int SPAN = 1 << W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] x_in, y_in, result;
    logic [3:0]   func_sel;
    logic         carry_out, overflow;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    sel_alu #(.WIDTH(W)) dut_i (
        .x_in      (x_in),
        .y_in      (y_in),
        .func_sel  (func_sel),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    // Expected {overflow, carry_out, result} from the requirement tables.
    function automatic logic [W+1:0] model(input logic [3:0] f,
                                           input logic [W-1:0] x,
                                           input logic [W-1:0] y);
        logic [W-1:0] p;
        logic [W:0]   full;
        int           tot;
        logic         ov;
        if (f[3]) begin
            case (f[1:0])
                2'b00:   return {2'b00, x & y};
                2'b01:   return {2'b00, x | y};
                2'b10:   return {2'b00, x ^ y};
                default: return {2'b00, ~x};
            endcase
        end
        case (f[2:1])
            2'b00:   p = '0;
            2'b01:   p = y;
            2'b10:   p = ~y;
            default: p = '1;
        endcase
        full = {1'b0, p} + {1'b0, x} + (W+1)'(f[0]);
        tot  = int'($signed(p)) + int'($signed(x)) + int'(f[0]);
        ov   = (tot > SPAN/2 - 1) || (tot < -(SPAN/2));
        return {ov, full[W], full[W-1:0]};
    endfunction

    task automatic check(input logic [3:0] f, input logic [W-1:0] x,
                         input logic [W-1:0] y, input string tag);
        logic [W+1:0] exp;
        @(posedge clk);
        func_sel = f;
        x_in     = x;
        y_in     = y;
        @(negedge clk);
        exp = model(f, x, y);
        n_run++;
        if ({overflow, carry_out, result} !== exp) begin
            n_fail++;
            $display("FAIL %s f=%b x=%b y=%b actual ovf/co/res=%b/%b/%b expected=%b/%b/%b",
                     tag, f, x, y, overflow, carry_out, result,
                     exp[W+1], exp[W], exp[W-1:0]);
        end
    endtask

    task automatic expect_val(input string tag, input logic [W+1:0] act,
                              input logic [W+1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        func_sel = '0;
        x_in     = '0;
        y_in     = '0;
        void'($urandom(32'd20240611));

        // Idle state: all-zero inputs give all-zero outputs (R1, R2)
        @(negedge clk);
        expect_val("R1 idle", {overflow, carry_out, result}, '0);

        // R9: -8 boundary, decrement and increment across the signed range
        check(4'b0110, 4'b1000, 4'b0000, "R9 dec -8");
        expect_val("R9 dec -8 exact", {overflow, carry_out, result}, {1'b1, 1'b1, 4'b0111});
        check(4'b0001, 4'b0111, 4'b0000, "R9 inc +7");
        expect_val("R9 inc +7 exact", {overflow, carry_out, result}, {1'b1, 1'b0, 4'b1000});

        // R7: carry without overflow, overflow without carry
        check(4'b0010, 4'b0111, 4'b1100, "R7 +7 + -4");
        expect_val("R7 +7 + -4 exact", {overflow, carry_out, result}, {1'b0, 1'b1, 4'b0011});
        check(4'b0010, 4'b0100, 4'b0101, "R7 +4 + +5");
        expect_val("R7 +4 + +5 exact", {overflow, carry_out, result}, {1'b1, 1'b0, 4'b1001});

        // R3: Y has no effect for operand codes 00 and 11
        for (int y = 0; y < SPAN; y++) begin
            check(4'b0110, 4'b0101, W'(y), "R3 dec ignores Y");
            expect_val("R3 dec ignores Y exact", {overflow, carry_out, result}, {1'b0, 1'b1, 4'b0100});
            check(4'b0111, 4'b1010, W'(y), "R3 transfer ignores Y");
            expect_val("R3 transfer ignores Y exact", {overflow, carry_out, result}, {1'b0, 1'b1, 4'b1010});
        end

        // R1: bit 2 has no effect on logic codes
        for (int f = 0; f < 4; f++) begin
            logic [W+1:0] lo_out;
            check({2'b10, 2'(f)}, 4'b1011, 4'b1110, "R1 logic bit2=0");
            lo_out = {overflow, carry_out, result};
            check({2'b11, 2'(f)}, 4'b1011, 4'b1110, "R1 logic bit2=1");
            expect_val("R1 bit2 ignored", {overflow, carry_out, result}, lo_out);
        end

        // Exhaustive sweep: R2 R5 R7 on arithmetic codes, R4 R6 R8 on logic codes
        for (int f = 0; f < 16; f++) begin
            for (int x = 0; x < SPAN; x++) begin
                for (int y = 0; y < SPAN; y++) begin
                    check(4'(f), W'(x), W'(y),
                          (f >= 8) ? "R4/R6/R8 logic sweep" : "R2/R5/R7 arith sweep");
                end
            end
        end

        // Seeded random mix
        for (int k = 0; k < 400; k++) begin
            check(4'($urandom), W'($urandom), W'($urandom), "R2/R4 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule